// File: doc/BRIEF.md
# Interrupt Merge and DMA Request Router

This block gathers interrupt requests from a fixed set of module slots, plus a DMA terminal-count event, and presents them to the host bus as one interrupt line. Each slot can be masked on its own. A global enable gates everything. When an accepted request arrives, the block sets an active flag and records a small source code. It then ignores every further request until the host clears the flag by writing the status register. Turning on DMA mode narrows the accepted sources to the terminal-count event alone.

The same byte-wide register port also does three other jobs. It selects which slot's request drives the DMA request line. It holds a module-select value for the surrounding logic. It serves an identification register that returns two fixed bytes in turn on successive reads.

Register map on the host port:

| Address | Name | Write | Read |
|---|---|---|---|
| 0 | control | updates the fields | returns the fields |
| 1 | mask | bit n masks slot n | returns the mask |
| 2 | status | any value clears the flag | bit 7 active flag, bits 1:0 source code |
| 3 | module select | bits 1:0 | returns bits 1:0 |
| 4 | identification | no effect | alternates 0x81 and 0x60 |

The control register holds these fields: bit 0 is the global enable, bit 1 is the DMA mode, and bits 3:2 are the DMA source select.

Top module: `irq_dma_hub`

## Requirements
- R1: After reset the interrupt output and the DMA request are low. The flag is clear, the source code is 0 and all slots are masked (mask reads 0x07). Global enable and DMA mode are off, the DMA select is 0 and the module select is 0.
- R2: A request on slot n is accepted only while bit n of the mask register (address 1) is 0. With the bit at 1 the request leaves the flag clear.
- R3: With control bit 0 at 0, no request is accepted. The interrupt output is low even while the flag is set, and it returns when the bit is set again.
- R4: An accepted request sets the flag at the next clock edge, and the interrupt output then stays high. While the flag is set, new requests neither change it nor change the source code. A write of any value to address 2 clears the flag at the next edge.
- R5: The source code is 0, 1 or 2 for slots 0, 1 and 2, and 3 for terminal count. When several enabled sources request in the same cycle, the lowest code is captured.
- R6: With control bit 1 set, slot requests are ignored and a terminal-count pulse is accepted with code 3. With control bit 1 clear, terminal count is ignored.
- R7: The DMA request output follows, one cycle later, the request of the slot selected by control bits 3:2 (00 slot 0, 01 slot 1, 10 slot 2). It stays low for select 11 and whenever control bit 1 is 0.
- R8: Reads of address 4 return 0x81 first after reset, then 0x60, and keep alternating.
- R9: The module-select output takes bits 1:0 of a write to address 3 when they are 00, 01 or 10. A write of 11 leaves the value unchanged.
- R10: Read data appears one cycle after the read strobe. Status reads show the flag in bit 7 and the source code in bits 1:0, and the code keeps its last captured value after a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| slot_irq | input | 3 | Interrupt request per slot |
| dma_tc | input | 1 | DMA terminal-count event |
| slot_dreq | input | 3 | DMA request per slot |
| irq_o | output | 1 | Bus interrupt |
| dma_req_o | output | 1 | Routed DMA request |
| mod_sel_o | output | 2 | Active module select |

## Verification
A flag stuck high shows up at once: the interrupt output stays high after a clear, and the status register still reports the flag. A flag that fails to latch or hold shows up one edge after the offending request, as a missing interrupt or a source code that changes during a second request. A wrong priority or mask decode shows up as the wrong code on the first status read after a multi-source pulse. A wrong DMA select or identification phase is visible on the next cycle's DMA request, or on the next read of address 4.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 3'd0,
    REG_MASK = 3'd1,
    REG_STAT = 3'd2,
    REG_MSEL = 3'd3,
    REG_IDENT = 3'd4
  } reg_addr_e;

  localparam int unsigned CTRL_GIE_BIT = 0;
  localparam int unsigned CTRL_DMA_BIT = 1;
  localparam int unsigned CTRL_SEL_LSB = 2;
endpackage

// File: rtl/irq_hub_regs.sv
module irq_hub_regs
  import irq_hub_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned NSLOT = 3,
  parameter logic [DW-1:0] ID_A = 8'h81,
  parameter logic [DW-1:0] ID_B = 8'h60,
  localparam int unsigned CW = $clog2(NSLOT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic              active,
  input  logic [CW-1:0]     code,
  output logic              gie,
  output logic              dma_en,
  output logic [CW-1:0]     dma_sel,
  output logic [NSLOT-1:0]  mask,
  output logic [CW-1:0]     mod_sel,
  output logic              clr
);
  logic          id_phase;
  logic [DW-1:0] rd_mux;
  logic          wr_msel_ok;
  logic          rd_id;

  assign clr        = wr_en && (addr == REG_STAT);
  assign rd_id      = rd_en && (addr == REG_IDENT);
  assign wr_msel_ok = wdata[CW-1:0] < CW'(NSLOT);

  always_ff @(posedge clk) begin
    if (rst) begin
      gie     <= 1'b0;
      dma_en  <= 1'b0;
      dma_sel <= '0;
      mask    <= '1;
      mod_sel <= '0;
    end else if (wr_en) begin
      case (addr)
        REG_CTRL: begin
          gie     <= wdata[CTRL_GIE_BIT];
          dma_en  <= wdata[CTRL_DMA_BIT];
          dma_sel <= wdata[CTRL_SEL_LSB +: CW];
        end
        REG_MASK: mask <= wdata[NSLOT-1:0];
        REG_MSEL: if (wr_msel_ok) mod_sel <= wdata[CW-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      REG_CTRL: begin
        rd_mux[CTRL_GIE_BIT]          = gie;
        rd_mux[CTRL_DMA_BIT]          = dma_en;
        rd_mux[CTRL_SEL_LSB +: CW]    = dma_sel;
      end
      REG_MASK:  rd_mux[NSLOT-1:0] = mask;
      REG_STAT: begin
        rd_mux[DW-1]   = active;
        rd_mux[CW-1:0] = code;
      end
      REG_MSEL:  rd_mux[CW-1:0] = mod_sel;
      REG_IDENT: rd_mux = id_phase ? ID_B : ID_A;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      id_phase <= 1'b0;
    end else if (rd_en) begin
      rdata <= rd_mux;
      if (rd_id) id_phase <= ~id_phase;
    end
  end

  AST_ID_VALUE: assert property (@(posedge clk) disable iff (rst)
    rd_id |=> (rdata == ID_A || rdata == ID_B)); // R8
  AST_MSEL_BAD_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == REG_MSEL && wdata[CW-1:0] >= CW'(NSLOT)) |=> $stable(mod_sel)); // R9
  AST_MSEL_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    mod_sel < CW'(NSLOT)); // R9
endmodule

// File: rtl/irq_hub_capture.sv
module irq_hub_capture #(
  parameter int unsigned NSLOT = 3,
  localparam int unsigned CW = $clog2(NSLOT + 1),
  localparam logic [CW-1:0] TC_CODE = CW'(NSLOT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSLOT-1:0] slot_irq,
  input  logic             dma_tc,
  input  logic [NSLOT-1:0] mask,
  input  logic             gie,
  input  logic             dma_en,
  input  logic             clr,
  output logic             active,
  output logic [CW-1:0]    code,
  output logic             irq_o
);
  logic [NSLOT-1:0] elig;
  logic             tc_hit;
  logic             any_req;
  logic [CW-1:0]    win;

  assign elig    = dma_en ? '0 : (slot_irq & ~mask);
  assign tc_hit  = dma_en & dma_tc;
  assign any_req = (|elig) | tc_hit;

  always_comb begin
    win = TC_CODE;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (elig[i]) win = CW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      code   <= '0;
    end else if (clr) begin
      active <= 1'b0;
    end else if (!active && gie && any_req) begin
      active <= 1'b1;
      code   <= win;
    end
  end

  assign irq_o = active & gie;

  AST_MASKED_NO_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (!active && (slot_irq & ~mask) == '0 && !(dma_en && dma_tc)) |=> !active); // R2
  AST_GIE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (!gie && !active) |=> !active); // R3
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (active && !clr) |=> (active && $stable(code))); // R4
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (rst)
    clr |=> !active); // R4
  AST_SLOT0_FIRST: assert property (@(posedge clk) disable iff (rst)
    (!active && !clr && gie && !dma_en && slot_irq[0] && !mask[0]) |=> (code == '0)); // R5
  AST_DMA_TC_ONLY: assert property (@(posedge clk) disable iff (rst)
    (dma_en && !active && !clr) |=> (!active || code == TC_CODE)); // R6
endmodule

// File: rtl/irq_hub_dma_route.sv
module irq_hub_dma_route #(
  parameter int unsigned NSLOT = 3,
  localparam int unsigned CW = $clog2(NSLOT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSLOT-1:0] slot_dreq,
  input  logic             dma_en,
  input  logic [CW-1:0]    dma_sel,
  output logic             dma_req_o
);
  logic [(1<<CW)-1:0] dreq_ext;

  assign dreq_ext = {{((1<<CW)-NSLOT){1'b0}}, slot_dreq};

  always_ff @(posedge clk) begin
    if (rst) dma_req_o <= 1'b0;
    else     dma_req_o <= dma_en && (dma_sel < CW'(NSLOT)) && dreq_ext[dma_sel];
  end

  AST_INVALID_SEL_QUIET: assert property (@(posedge clk) disable iff (rst)
    (dma_sel >= CW'(NSLOT)) |=> !dma_req_o); // R7
  AST_DMA_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    !dma_en |=> !dma_req_o); // R7
endmodule

// File: rtl/irq_dma_hub.sv
module irq_dma_hub
  import irq_hub_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned NSLOT = 3,
  parameter logic [DW-1:0] ID_A = 8'h81,
  parameter logic [DW-1:0] ID_B = 8'h60,
  localparam int unsigned CW = $clog2(NSLOT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic [NSLOT-1:0]  slot_irq,
  input  logic              dma_tc,
  input  logic [NSLOT-1:0]  slot_dreq,
  output logic              irq_o,
  output logic              dma_req_o,
  output logic [CW-1:0]     mod_sel_o
);
  logic             gie, dma_en, clr, active;
  logic [CW-1:0]    dma_sel, code;
  logic [NSLOT-1:0] mask;

  irq_hub_regs #(.DW(DW), .NSLOT(NSLOT), .ID_A(ID_A), .ID_B(ID_B)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .active(active), .code(code),
    .gie(gie), .dma_en(dma_en), .dma_sel(dma_sel), .mask(mask),
    .mod_sel(mod_sel_o), .clr(clr)
  );

  irq_hub_capture #(.NSLOT(NSLOT)) cap_i (
    .clk(clk), .rst(rst), .slot_irq(slot_irq), .dma_tc(dma_tc),
    .mask(mask), .gie(gie), .dma_en(dma_en), .clr(clr),
    .active(active), .code(code), .irq_o(irq_o)
  );

  irq_hub_dma_route #(.NSLOT(NSLOT)) route_i (
    .clk(clk), .rst(rst), .slot_dreq(slot_dreq), .dma_en(dma_en),
    .dma_sel(dma_sel), .dma_req_o(dma_req_o)
  );
endmodule

// File: tb/irq_dma_hub_tb.sv
module irq_dma_hub_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [2:0] slot_irq = '0, slot_dreq = '0;
  logic       dma_tc = 1'b0;
  logic       irq_o, dma_req_o;
  logic [1:0] mod_sel_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_dma_hub dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .slot_irq(slot_irq), .dma_tc(dma_tc),
    .slot_dreq(slot_dreq), .irq_o(irq_o), .dma_req_o(dma_req_o),
    .mod_sel_o(mod_sel_o)
  );

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic pulse(logic [2:0] s, logic tc);
    @(negedge clk); slot_irq = s; dma_tc = tc;
    @(negedge clk); slot_irq = '0; dma_tc = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 irq", {7'b0, irq_o}, 8'h00);
    check("R1 dma_req", {7'b0, dma_req_o}, 8'h00);
    check("R1 mod_sel", {6'b0, mod_sel_o}, 8'h00);
    rd(3'd2, d); check("R1 status", d, 8'h00);
    rd(3'd1, d); check("R1 mask", d, 8'h07);
    rd(3'd0, d); check("R1 ctrl", d, 8'h00);
  endtask

  task automatic t_mask_latch();
    logic [7:0] d;
    wr(3'd0, 8'h01);
    pulse(3'b010, 1'b0); check("R2 masked slot1", {7'b0, irq_o}, 8'h00);
    wr(3'd1, 8'h05);
    pulse(3'b010, 1'b0); check("R4 irq set", {7'b0, irq_o}, 8'h01);
    rd(3'd2, d); check("R10 status slot1", d, 8'h81);
    wr(3'd1, 8'h00);
    pulse(3'b001, 1'b0);
    rd(3'd2, d); check("R4 code held", d, 8'h81);
    check("R4 irq held", {7'b0, irq_o}, 8'h01);
    wr(3'd2, 8'h5a); check("R4 cleared", {7'b0, irq_o}, 8'h00);
    rd(3'd2, d); check("R10 code kept", d, 8'h01);
  endtask

  task automatic t_priority();
    logic [7:0] d;
    pulse(3'b110, 1'b0); rd(3'd2, d); check("R5 lowest of 1,2", d, 8'h81);
    wr(3'd2, 8'h00);
    pulse(3'b111, 1'b0); rd(3'd2, d); check("R5 lowest of all", d, 8'h80);
    wr(3'd2, 8'h00);
    pulse(3'b100, 1'b0); rd(3'd2, d); check("R5 slot2 code", d, 8'h82);
    wr(3'd2, 8'h00);
  endtask

  task automatic t_gie();
    logic [7:0] d;
    wr(3'd0, 8'h00);
    pulse(3'b001, 1'b0); check("R3 no irq", {7'b0, irq_o}, 8'h00);
    rd(3'd2, d); check("R3 no capture", d, 8'h02);
    wr(3'd0, 8'h01);
    pulse(3'b001, 1'b0); check("R3 irq on", {7'b0, irq_o}, 8'h01);
    wr(3'd0, 8'h00); check("R3 gated off", {7'b0, irq_o}, 8'h00);
    wr(3'd0, 8'h01); check("R3 back on", {7'b0, irq_o}, 8'h01);
    wr(3'd2, 8'h00);
  endtask

  task automatic t_dma_irq();
    logic [7:0] d;
    wr(3'd0, 8'h03);
    pulse(3'b111, 1'b0); check("R6 slots ignored", {7'b0, irq_o}, 8'h00);
    pulse(3'b000, 1'b1); check("R6 tc accepted", {7'b0, irq_o}, 8'h01);
    rd(3'd2, d); check("R5 tc code", d, 8'h83);
    wr(3'd2, 8'h00);
    wr(3'd0, 8'h01);
    pulse(3'b000, 1'b1); check("R6 tc ignored", {7'b0, irq_o}, 8'h00);
  endtask

  task automatic t_route();
    for (int s = 0; s < 3; s++) begin
      wr(3'd0, 8'h02 | 8'(s << 2));
      @(negedge clk); slot_dreq = 3'(1 << s);
      @(negedge clk); check($sformatf("R7 sel %0d hit", s), {7'b0, dma_req_o}, 8'h01);
      slot_dreq = 3'b111 & ~3'(1 << s);
      @(negedge clk); check($sformatf("R7 sel %0d others", s), {7'b0, dma_req_o}, 8'h00);
    end
    wr(3'd0, 8'h0e);
    @(negedge clk); slot_dreq = 3'b111;
    @(negedge clk); check("R7 sel 11", {7'b0, dma_req_o}, 8'h00);
    wr(3'd0, 8'h04);
    @(negedge clk); check("R7 dma off", {7'b0, dma_req_o}, 8'h00);
    slot_dreq = '0;
  endtask

  task automatic t_ident();
    logic [7:0] d;
    rd(3'd4, d); check("R8 first", d, 8'h81);
    rd(3'd4, d); check("R8 second", d, 8'h60);
    rd(3'd4, d); check("R8 third", d, 8'h81);
  endtask

  task automatic t_modsel();
    logic [7:0] d;
    wr(3'd3, 8'h02); check("R9 set 2", {6'b0, mod_sel_o}, 8'h02);
    wr(3'd3, 8'h03); check("R9 11 ignored", {6'b0, mod_sel_o}, 8'h02);
    rd(3'd3, d); check("R9 readback", d, 8'h02);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_mask_latch();
    t_priority();
    t_gie();
    t_dma_irq();
    t_route();
    t_ident();
    t_modsel();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule